// File: doc/BRIEF.md
# Built-in Test Mode Controller

This block sequences the self-test modes of a four-channel position converter. A host writes a mode register with three independent mode bits. The loopback bit routes a host-written test value to the converter core. The background bit lets per-channel accuracy results stream in continuously while the channels keep running. The initiated bit runs a timed multi-step test cycle and clears itself when the cycle ends. While loopback or the initiated test is on, the block isolates the channel inputs from the field wiring.

Measurement results arrive from a comparison stub as a valid/ready stream of per-channel pass flags. The block raises `meas_ready` only while a mode that consumes results is on. A result offered while `meas_ready` is low stays with the stub and does not affect the block. A heartbeat byte is rewritten with 55h on every accepted background result, so the host can clear it and read it again later to confirm that the background test is still running. An active-channel mask keeps unused channels from ever reporting a fault. The initiated test can also start by itself out of reset when a saved power-on enable is present.

Top module: `bist_mode_ctrl`

## Requirements
- R1: After reset the loopback and background bits are 0, the initiated bit equals `post_saved_en`, `test_status` is 4'b1111, `heartbeat` is 00h and `active_mask` is 4'b1111.
- R2: A mode write (select 0) loads bit 0 = loopback, bit 2 = background, bit 3 = initiated test. `test_en` bit 1 always reads 0, and the other data bits are ignored.
- R3: `inputs_isolated` is 1 exactly when the loopback bit or the initiated bit is set.
- R4: An initiated test keeps bit 3 at 1 for NSTEPS*STEP_TICKS cycles. `init_step` advances by one every STEP_TICKS cycles, starting at 0. Bit 3 then returns to 0 by itself.
- R5: At the end of the cycle, each channel's `test_status` bit is the AND of the pass flags of all results accepted during the run. If the host clears bit 3 before the end, the run aborts, `init_step` returns to 0 and `test_status` keeps its previous value.
- R6: A result accepted while the background bit is set and the initiated bit is clear loads `test_status` from `meas_pass` (bit n = channel n+1, 1 = pass) and writes 55h to `heartbeat`. Both take effect in the next cycle.
- R7: The host may write `heartbeat` (select 2, data bits 7:0). A host write wins over a background rewrite in the same cycle. With the background bit clear, `heartbeat` and `test_status` keep their values.
- R8: `meas_ready` is 1 exactly when the background or initiated bit is set. A result offered while `meas_ready` is 0 changes nothing.
- R9: `link_status` bit n is `chan_ok[n]` for an active channel. For a channel whose `active_mask` bit is 0, both `link_status` and `test_status` read 1. The mask is written with select 1, data bits 3:0.
- R10: A select-3 write loads `loop_value`. `loop_drive` equals the loopback bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_saved_en | input | 1 | Saved power-on test enable, sampled in reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | 0 mode, 1 active mask, 2 heartbeat, 3 loopback value |
| cfg_wdata | input | 16 | Host write data |
| chan_ok | input | 4 | Per channel: excitation and signal both present |
| meas_valid | input | 1 | Result stream valid |
| meas_ready | output | 1 | Result stream ready |
| meas_pass | input | 4 | Per-channel pass flags of the offered result |
| test_en | output | 4 | Mode register readback |
| inputs_isolated | output | 1 | Disconnect channel inputs, select internal stimulus |
| init_step | output | SW | Current step of the initiated test |
| loop_drive | output | 1 | Loopback value is driving the converter |
| loop_value | output | 16 | Host-written loopback input value |
| link_status | output | 4 | Masked excitation/signal status |
| test_status | output | 4 | Masked accuracy pass status |
| heartbeat | output | 8 | Background-alive byte |
| active_mask | output | 4 | Active-channel mask readback |

## Verification
A stuck or mistimed step counter shows up at the ports as bit 3 of `test_en` falling a cycle early or late. It would also show as `init_step` advancing at the wrong cycle, so the bench counts every cycle of the run. A wrong pass accumulator or wrong background path appears in `test_status` one cycle after the deciding result. A heartbeat that misses a rewrite, or rewrites over a host clear, is visible in the cycle after the strobe. A mask applied to the wrong side would make an inactive channel read 0 in `link_status` or `test_status` as soon as its inputs drop.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_ACTIVE = 2'd1,
    SEL_BEAT   = 2'd2,
    SEL_LOOP   = 2'd3
  } cfg_sel_e;

  localparam int MODE_LOOP = 0;
  localparam int MODE_BG   = 2;
  localparam int MODE_INIT = 3;
  localparam logic [7:0] BEAT_MARK = 8'h55;
endpackage

// File: rtl/bist_seq.sv
module bist_seq #(
  parameter int STEP_TICKS = 250_000_000,
  parameter int NSTEPS     = 10,
  localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1,
  localparam int SW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [SW-1:0] step,
  output logic          done
);
  localparam logic [TW-1:0] TICK_LAST = TW'(STEP_TICKS - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(NSTEPS - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tick <= '0;
      step <= '0;
    end else if (tick == TICK_LAST) begin
      tick <= '0;
      step <= (step == STEP_LAST) ? '0 : step + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign done = run && (tick == TICK_LAST) && (step == STEP_LAST);

  p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_LAST);
  p_abort_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (step == '0));
endmodule

// File: rtl/bist_result.sv
module bist_result #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] active,
  input  logic [NCH-1:0] chan_ok,
  input  logic           bg_on,
  input  logic           init_on,
  input  logic           init_done,
  input  logic           meas_valid,
  output logic           meas_ready,
  input  logic [NCH-1:0] meas_pass,
  input  logic           beat_we,
  input  logic [7:0]     beat_wdata,
  output logic [NCH-1:0] link_status,
  output logic [NCH-1:0] test_status,
  output logic [7:0]     heartbeat
);
  import bist_pkg::*;

  logic           take, bg_take;
  logic [NCH-1:0] acc, acc_now, result_r;

  assign meas_ready = bg_on | init_on;
  assign take       = meas_valid & meas_ready;
  assign bg_take    = take & bg_on & ~init_on;
  assign acc_now    = (take && init_on) ? (acc & meas_pass) : acc;

  always_ff @(posedge clk) begin
    if (!rst_n || !init_on) acc <= '1;
    else                    acc <= acc_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         result_r <= '1;
    else if (init_done) result_r <= acc_now;
    else if (bg_take)   result_r <= meas_pass;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       heartbeat <= '0;
    else if (beat_we) heartbeat <= beat_wdata;
    else if (bg_take) heartbeat <= BEAT_MARK;
  end

  assign test_status = result_r | ~active;
  assign link_status = chan_ok  | ~active;

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~active) & ~(test_status & link_status)) == '0);
  p_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_take && !beat_we) |=> (heartbeat == BEAT_MARK));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_on && !init_on) |=> $stable(result_r));
endmodule

// File: rtl/bist_mode_ctrl.sv
module bist_mode_ctrl #(
  parameter int NCH        = 4,
  parameter int STEP_TICKS = 250_000_000,
  parameter int NSTEPS     = 10,
  parameter int DW         = 16,
  localparam int SW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           post_saved_en,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] chan_ok,
  input  logic           meas_valid,
  output logic           meas_ready,
  input  logic [NCH-1:0] meas_pass,
  output logic [3:0]     test_en,
  output logic           inputs_isolated,
  output logic [SW-1:0]  init_step,
  output logic           loop_drive,
  output logic [DW-1:0]  loop_value,
  output logic [NCH-1:0] link_status,
  output logic [NCH-1:0] test_status,
  output logic [7:0]     heartbeat,
  output logic [NCH-1:0] active_mask
);
  import bist_pkg::*;

  cfg_sel_e sel;
  logic     loop_r, bg_r, init_r, init_done;
  logic     wr_mode, wr_active, wr_beat, wr_loop;

  assign sel       = cfg_sel_e'(cfg_sel);
  assign wr_mode   = cfg_we && (sel == SEL_MODE);
  assign wr_active = cfg_we && (sel == SEL_ACTIVE);
  assign wr_beat   = cfg_we && (sel == SEL_BEAT);
  assign wr_loop   = cfg_we && (sel == SEL_LOOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_r <= 1'b0;
      bg_r   <= 1'b0;
      init_r <= post_saved_en;
    end else if (wr_mode) begin
      loop_r <= cfg_wdata[MODE_LOOP];
      bg_r   <= cfg_wdata[MODE_BG];
      init_r <= cfg_wdata[MODE_INIT];
    end else if (init_done) begin
      init_r <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '1;
      loop_value  <= '0;
    end else begin
      if (wr_active) active_mask <= cfg_wdata[NCH-1:0];
      if (wr_loop)   loop_value  <= cfg_wdata;
    end
  end

  assign test_en         = {init_r, bg_r, 1'b0, loop_r};
  assign inputs_isolated = loop_r | init_r;
  assign loop_drive      = loop_r;

  bist_seq #(.STEP_TICKS(STEP_TICKS), .NSTEPS(NSTEPS)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (init_r),
    .step (init_step),
    .done (init_done)
  );

  bist_result #(.NCH(NCH)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active_mask),
    .chan_ok    (chan_ok),
    .bg_on      (bg_r),
    .init_on    (init_r),
    .init_done  (init_done),
    .meas_valid (meas_valid),
    .meas_ready (meas_ready),
    .meas_pass  (meas_pass),
    .beat_we    (wr_beat),
    .beat_wdata (cfg_wdata[7:0]),
    .link_status(link_status),
    .test_status(test_status),
    .heartbeat  (heartbeat)
  );

  p_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !wr_mode) |=> !test_en[MODE_INIT]);
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ready |-> !test_en[MODE_INIT]);
endmodule

// File: tb/tb_bist_mode_ctrl.sv
`timescale 1ns/1ps
module tb_bist_mode_ctrl;
  localparam int NCH = 4, ST = 5, NS = 4, DW = 16;
  localparam int SW = $clog2(NS);

  logic clk = 0, rst_n = 0, post_saved_en = 0, cfg_we = 0, meas_valid = 0;
  logic [1:0] cfg_sel = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic [NCH-1:0] chan_ok = '1, meas_pass = 0;
  logic meas_ready, inputs_isolated, loop_drive;
  logic [3:0] test_en;
  logic [SW-1:0] init_step;
  logic [DW-1:0] loop_value;
  logic [NCH-1:0] link_status, test_status, active_mask;
  logic [7:0] heartbeat;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bist_mode_ctrl #(.NCH(NCH), .STEP_TICKS(ST), .NSTEPS(NS), .DW(DW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe(input logic [NCH-1:0] p);
    meas_valid = 1; meas_pass = p;
    @(negedge clk);
    meas_valid = 0;
  endtask

  task automatic do_reset(input logic post);
    post_saved_en = post; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(0);
    chk("R1 test_en", test_en, 4'b0000);
    chk("R1 test_status", test_status, 4'hF);
    chk("R1 heartbeat", heartbeat, 8'h00);
    chk("R1 active_mask", active_mask, 4'hF);
    chk("R3 isolated idle", inputs_isolated, 0);
    chk("R8 ready idle", meas_ready, 0);
  endtask

  task automatic t_mode_bits();
    wr(0, 16'hFFF7);
    chk("R2 mode bits", test_en, 4'b0101);
    chk("R3 isolated loop", inputs_isolated, 1);
    chk("R8 ready bg", meas_ready, 1);
    wr(0, 16'h0004);
    chk("R3 isolated bg only", inputs_isolated, 0);
    wr(0, 16'h0000);
    chk("R2 cleared", test_en, 4'b0000);
  endtask

  task automatic t_loopback();
    wr(3, 16'h1234);
    wr(0, 16'h0001);
    chk("R10 loop_value", loop_value, 16'h1234);
    chk("R10 loop_drive", loop_drive, 1);
    wr(0, 16'h0000);
    chk("R10 loop_drive off", loop_drive, 0);
  endtask

  task automatic t_ignored();
    strobe(4'b0000);
    chk("R8 ignored status", test_status, 4'hF);
    chk("R8 ignored beat", heartbeat, 8'h00);
  endtask

  task automatic t_background();
    wr(0, 16'h0004);
    strobe(4'b0110);
    chk("R6 bg status", test_status, 4'b0110);
    chk("R6 bg beat", heartbeat, 8'h55);
    wr(2, 16'h0000);
    chk("R7 host clear", heartbeat, 8'h00);
    strobe(4'b1001);
    chk("R6 beat again", heartbeat, 8'h55);
    cfg_we = 1; cfg_sel = 2; cfg_wdata = 16'h0000;
    meas_valid = 1; meas_pass = 4'b1001;
    @(negedge clk);
    cfg_we = 0; meas_valid = 0;
    chk("R7 host wins", heartbeat, 8'h00);
    wr(0, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R7 no rewrite", heartbeat, 8'h00);
    chk("R7 status held", test_status, 4'b1001);
  endtask

  task automatic t_mask();
    wr(1, 16'h0005);
    chan_ok = 4'b0000;
    @(negedge clk);
    chk("R9 link masked", link_status, 4'b1010);
    chk("R9 test masked", test_status, 4'b1011);
    chan_ok = 4'b1111;
    wr(1, 16'h000F);
    chk("R9 link all", link_status, 4'hF);
  endtask

  task automatic t_initiated();
    wr(0, 16'h0008);
    chk("R3 isolated init", inputs_isolated, 1);
    for (int i = 1; i <= NS*ST; i++) begin
      meas_valid = (i == 2) || (i == 3);
      meas_pass  = (i == 2) ? 4'b1111 : 4'b1011;
      @(negedge clk);
      meas_valid = 0;
      if (i == ST)         chk("R4 step one", init_step, 1);
      if (i == NS*ST - 1)  chk("R4 still running", test_en[3], 1);
      if (i == NS*ST - 1)  chk("R5 not yet loaded", test_status, 4'b1001);
      if (i == NS*ST)      chk("R4 self clear", test_en[3], 0);
    end
    chk("R5 init result", test_status, 4'b1011);
    chk("R3 released", inputs_isolated, 0);
  endtask

  task automatic t_abort();
    wr(0, 16'h0008);
    strobe(4'b0000);
    @(negedge clk);
    wr(0, 16'h0000);
    chk("R5 abort bit", test_en[3], 0);
    chk("R5 abort step", init_step, 0);
    chk("R5 abort held", test_status, 4'b1011);
  endtask

  task automatic t_post();
    do_reset(1);
    chk("R1 post start", test_en, 4'b1000);
    chk("R3 post isolated", inputs_isolated, 1);
    repeat (NS*ST) @(negedge clk);
    chk("R4 post done", test_en[3], 0);
    chk("R1 post status", test_status, 4'hF);
  endtask

  initial begin
    t_reset_state();
    t_mode_bits();
    t_loopback();
    t_ignored();
    t_background();
    t_mask();
    t_initiated();
    t_abort();
    t_post();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule